// File: doc/BRIEF.md
# Banked Internal Data RAM with Bit Addressing

A 128-byte on-chip data store that a processor core reaches in three ways at once. A flat byte port reads and writes any of the 128 locations. A register port names one of eight working registers, and the currently active bank turns that name into a byte location. A single-bit port sets, clears or reads one bit inside a 16-byte bit region. All three views share one storage array, so a value written through one port can be read back through the others.

The active bank is a two-bit value held inside the block. It is loaded through its own write strobe and shown on an output. A bit write is a read-modify-write of the byte that contains the bit, and it completes in the same cycle as the request. Every read port returns registered data one cycle after its address is presented. Reset clears the bank and the read outputs. It leaves the stored bytes as they were.

Top module: `iram_top`

## Requirements
- R1: A byte-port write stores `byte_wdata` at `byte_addr` (0x00 to 0x7F). `byte_rdata` shows the content of the address presented in the previous cycle.
- R2: On the register port, register index n of active bank b is byte location b*8+n. Writes through either port are visible through the other.
- R3: The active bank is 0 after reset. When `bank_we` is high, `bank_wdata` is loaded at the clock edge. `bank_o` shows the new bank from the next cycle, and the register port uses it from that cycle on. With `bank_we` low the bank holds.
- R4: Bit address a (0x00 to 0x7F) names byte 0x20 + (a >> 3) at bit position a & 7, where position 0 is the least significant bit. `bit_rdata` returns that bit one cycle after `bit_addr` is presented.
- R5: A bit write sets the addressed bit to `bit_wval` and leaves the other seven bits of its byte unchanged.
- R6: When a byte-port write and either a bit write or a register write hit the same byte in one cycle, the byte-port value is stored.
- R7: A read of a location in the same cycle as a write to it returns the content from before the write.
- R8: While reset is low, `bank_o`, `byte_rdata`, `reg_rdata` and `bit_rdata` are 0. Reset does not change any stored byte.
- R9: Register-port and bit-port writes never change bytes 0x30 to 0x7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_we | input | 1 | Load the active bank |
| bank_wdata | input | 2 | New active bank |
| bank_o | output | 2 | Current active bank |
| byte_addr | input | 7 | Byte-port address |
| byte_we | input | 1 | Byte-port write strobe |
| byte_wdata | input | 8 | Byte-port write data |
| byte_rdata | output | 8 | Byte-port read data, one cycle latency |
| reg_idx | input | 3 | Register index within the active bank |
| reg_we | input | 1 | Register-port write strobe |
| reg_wdata | input | 8 | Register-port write data |
| reg_rdata | output | 8 | Register-port read data, one cycle latency |
| bit_addr | input | 7 | Bit address |
| bit_we | input | 1 | Bit write strobe |
| bit_wval | input | 1 | Value written to the addressed bit |
| bit_rdata | output | 1 | Bit read data, one cycle latency |

## Verification
Two pairs of operations can land on the same byte in one cycle. A byte-port write can meet a bit write inside 0x20 to 0x2F. A byte-port write can meet a register write inside 0x00 to 0x1F. Directed passes raise both strobes on the same byte with data chosen so that the two outcomes differ. In the bit case, the bit write carries the inverse of the byte's own bit. Long random passes then mix all three ports with bank changes. The result is judged by reading the byte back through the byte port and comparing it, cycle by cycle, with a behavioural model that applies the byte-port write last.

// File: rtl/iram_pkg.sv
package iram_pkg;
    localparam int IRAM_DEPTH = 128;
    localparam int IRAM_AW    = $clog2(IRAM_DEPTH);
    localparam int IRAM_DW    = 8;

    // one write request into the shared array
    typedef struct packed {
        logic               en;
        logic [IRAM_AW-1:0] addr;
        logic [IRAM_DW-1:0] data;
    } iram_wr_t;
endpackage

// File: rtl/iram_store.sv
module iram_store
    import iram_pkg::*;
#(
    parameter int NUM_WR = 3,
    parameter int NUM_RD = 3
) (
    input  logic               clk,
    input  iram_wr_t           wr_i      [NUM_WR],
    input  logic [IRAM_AW-1:0] rd_addr_i [NUM_RD],
    output logic [IRAM_DW-1:0] rd_data_o [NUM_RD]
);
    logic [IRAM_DW-1:0] mem_d [IRAM_DEPTH];
    logic [IRAM_DW-1:0] mem_q [IRAM_DEPTH];

    // lowest request index is applied last and therefore wins
    always_comb begin
        mem_d = mem_q;
        for (int w = NUM_WR - 1; w >= 0; w--) begin
            if (wr_i[w].en) begin
                mem_d[wr_i[w].addr] = wr_i[w].data;
            end
        end
    end

    // contents are deliberately not reset
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        assign rd_data_o[r] = mem_q[rd_addr_i[r]];
    end
endmodule

// File: rtl/iram_reg_map.sv
module iram_reg_map
    import iram_pkg::*;
#(
    parameter  int NUM_BANKS     = 4,
    parameter  int REGS_PER_BANK = 8,
    localparam int BANK_W        = $clog2(NUM_BANKS),
    localparam int IDX_W         = $clog2(REGS_PER_BANK)
) (
    input  logic [BANK_W-1:0]  bank_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [IRAM_AW-1:0] addr_o
);
    assign addr_o = IRAM_AW'(bank_i) * IRAM_AW'(REGS_PER_BANK) + IRAM_AW'(idx_i);
endmodule

// File: rtl/iram_bit_map.sv
module iram_bit_map
    import iram_pkg::*;
#(
    parameter  int BIT_BASE  = 32,
    parameter  int BIT_BYTES = 16,
    localparam int BI_W      = $clog2(IRAM_DW),
    localparam int BA_W      = $clog2(BIT_BYTES * IRAM_DW)
) (
    input  logic [BA_W-1:0]    bit_addr_i,
    output logic [IRAM_AW-1:0] byte_addr_o,
    output logic [BI_W-1:0]    bit_idx_o
);
    assign bit_idx_o   = bit_addr_i[BI_W-1:0];
    assign byte_addr_o = IRAM_AW'(BIT_BASE) + IRAM_AW'(bit_addr_i[BA_W-1:BI_W]);
endmodule

// File: rtl/iram_top.sv
module iram_top
    import iram_pkg::*;
#(
    parameter  int NUM_BANKS     = 4,
    parameter  int REGS_PER_BANK = 8,
    parameter  int BIT_BASE      = 32,
    parameter  int BIT_BYTES     = 16,
    localparam int BANK_W        = $clog2(NUM_BANKS),
    localparam int IDX_W         = $clog2(REGS_PER_BANK),
    localparam int BI_W          = $clog2(IRAM_DW),
    localparam int BA_W          = $clog2(BIT_BYTES * IRAM_DW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bank_we,
    input  logic [BANK_W-1:0]  bank_wdata,
    output logic [BANK_W-1:0]  bank_o,
    input  logic [IRAM_AW-1:0] byte_addr,
    input  logic               byte_we,
    input  logic [IRAM_DW-1:0] byte_wdata,
    output logic [IRAM_DW-1:0] byte_rdata,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic               reg_we,
    input  logic [IRAM_DW-1:0] reg_wdata,
    output logic [IRAM_DW-1:0] reg_rdata,
    input  logic [BA_W-1:0]    bit_addr,
    input  logic               bit_we,
    input  logic               bit_wval,
    output logic               bit_rdata
);
    localparam int PORT_BYTE = 0;
    localparam int PORT_REG  = 1;
    localparam int PORT_BIT  = 2;
    localparam int NUM_PORTS = 3;

    typedef struct packed {
        logic [BANK_W-1:0]  bank;
        logic [IRAM_DW-1:0] byte_rd;
        logic [IRAM_DW-1:0] reg_rd;
        logic               bit_rd;
    } state_t;

    state_t st_d, st_q;

    logic [IRAM_AW-1:0] reg_addr;
    logic [IRAM_AW-1:0] bit_byte_addr;
    logic [BI_W-1:0]    bit_idx;
    logic [IRAM_DW-1:0] bit_merged;
    logic [IRAM_AW-1:0] rd_addr [NUM_PORTS];
    logic [IRAM_DW-1:0] rd_data [NUM_PORTS];
    iram_wr_t           wr_req  [NUM_PORTS];

    iram_reg_map #(
        .NUM_BANKS     (NUM_BANKS),
        .REGS_PER_BANK (REGS_PER_BANK)
    ) u_reg_map (
        .bank_i (st_q.bank),
        .idx_i  (reg_idx),
        .addr_o (reg_addr)
    );

    iram_bit_map #(
        .BIT_BASE  (BIT_BASE),
        .BIT_BYTES (BIT_BYTES)
    ) u_bit_map (
        .bit_addr_i  (bit_addr),
        .byte_addr_o (bit_byte_addr),
        .bit_idx_o   (bit_idx)
    );

    assign rd_addr[PORT_BYTE] = byte_addr;
    assign rd_addr[PORT_REG]  = reg_addr;
    assign rd_addr[PORT_BIT]  = bit_byte_addr;

    // same-cycle read-modify-write of the byte holding the bit
    always_comb begin
        bit_merged          = rd_data[PORT_BIT];
        bit_merged[bit_idx] = bit_wval;
    end

    // request order sets priority: byte port first
    assign wr_req[PORT_BYTE] = '{en: byte_we, addr: byte_addr,     data: byte_wdata};
    assign wr_req[PORT_REG]  = '{en: reg_we,  addr: reg_addr,      data: reg_wdata};
    assign wr_req[PORT_BIT]  = '{en: bit_we,  addr: bit_byte_addr, data: bit_merged};

    iram_store #(
        .NUM_WR (NUM_PORTS),
        .NUM_RD (NUM_PORTS)
    ) u_store (
        .clk       (clk),
        .wr_i      (wr_req),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    always_comb begin
        st_d         = st_q;
        st_d.byte_rd = rd_data[PORT_BYTE];
        st_d.reg_rd  = rd_data[PORT_REG];
        st_d.bit_rd  = rd_data[PORT_BIT][bit_idx];
        if (bank_we) begin
            st_d.bank = bank_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_o     = st_q.bank;
    assign byte_rdata = st_q.byte_rd;
    assign reg_rdata  = st_q.reg_rd;
    assign bit_rdata  = st_q.bit_rd;
endmodule

// File: rtl/iram_chk.sv
module iram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bank_we,
    input logic [1:0] bank_wdata,
    input logic [1:0] bank_o,
    input logic [6:0] byte_addr,
    input logic       byte_we,
    input logic [7:0] byte_wdata,
    input logic [7:0] byte_rdata,
    input logic [7:0] reg_rdata,
    input logic [6:0] bit_addr,
    input logic       bit_we,
    input logic       bit_wval,
    input logic       bit_rdata
);
    // R3
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> (bank_o == $past(bank_wdata)));

    // R3
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(bank_o));

    // R8
    reset_zero_chk: assert property (@(posedge clk)
        (!rst_n ##1 !rst_n) |-> (bank_o == 2'd0 && byte_rdata == 8'd0 &&
                                 reg_rdata == 8'd0 && !bit_rdata));

    // R1 R6 R7
    byte_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we ##1 (byte_addr == $past(byte_addr))) |=>
            (byte_rdata == $past(byte_wdata, 2)));

    // R4 R5
    bit_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_we && !(byte_we && byte_addr == {3'b010, bit_addr[6:3]})) ##1
         (bit_addr == $past(bit_addr))) |=> (bit_rdata == $past(bit_wval, 2)));
endmodule

bind iram_top iram_chk u_chk (.*);

// File: tb/iram_top_bench.sv
`timescale 1ns/1ps
module iram_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_we;
    logic [1:0] bank_wdata;
    logic [1:0] bank_o;
    logic [6:0] byte_addr;
    logic       byte_we;
    logic [7:0] byte_wdata;
    logic [7:0] byte_rdata;
    logic [2:0] reg_idx;
    logic       reg_we;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [6:0] bit_addr;
    logic       bit_we;
    logic       bit_wval;
    logic       bit_rdata;

    int    checks = 0;
    int    fails  = 0;
    string ph     = "R8";
    bit    done   = 1'b0;

    always #2.5 clk = ~clk;

    iram_top u_iram_top (.*);

    // behavioural model
    logic [7:0] m  [128];
    bit         mk [128];
    logic [1:0] e_bank;
    logic [7:0] e_byte, e_reg;
    logic       e_bit;
    bit         e_byte_k, e_reg_k, e_bit_k;
    int         ra, bb, bi;

    initial begin
        for (int i = 0; i < 128; i++) mk[i] = 1'b0;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_bank <= 2'd0; e_byte <= 8'd0; e_reg <= 8'd0; e_bit <= 1'b0;
            e_byte_k <= 1'b1; e_reg_k <= 1'b1; e_bit_k <= 1'b1;
        end else begin
            ra = int'(e_bank) * 8 + int'(reg_idx);
            bb = 32 + int'(bit_addr) / 8;
            bi = int'(bit_addr) % 8;
            e_byte <= m[byte_addr]; e_byte_k <= mk[byte_addr];
            e_reg  <= m[ra];        e_reg_k  <= mk[ra];
            e_bit  <= m[bb][bi];    e_bit_k  <= mk[bb];
            if (bit_we)  m[bb][bi] = bit_wval;
            if (reg_we)  begin m[ra] = reg_wdata; mk[ra] = 1'b1; end
            if (byte_we) begin m[byte_addr] = byte_wdata; mk[byte_addr] = 1'b1; end
            if (bank_we) e_bank <= bank_wdata;
        end
    end

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", ph, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("bank_o", {6'd0, bank_o}, {6'd0, e_bank});
            if (e_byte_k) chk("byte_rdata", byte_rdata, e_byte);
            if (e_reg_k)  chk("reg_rdata", reg_rdata, e_reg);
            if (e_bit_k)  chk("bit_rdata", {7'd0, bit_rdata}, {7'd0, e_bit});
        end
    end

    task automatic quiet();
        bank_we = 1'b0; byte_we = 1'b0; reg_we = 1'b0; bit_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        quiet();
        bank_wdata = 2'd0; byte_addr = '0; byte_wdata = '0; reg_idx = '0;
        reg_wdata = '0; bit_addr = '0; bit_wval = 1'b0;
        ph = "R8 reset";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        ph = "R1 R7 fill";
        for (int a = 0; a < 128; a++) begin
            @(negedge clk);
            byte_we = 1'b1; byte_addr = 7'(a); byte_wdata = 8'(a * 7 + 3);
        end
        @(negedge clk); quiet();
        ph = "R1 sweep";
        for (int a = 0; a < 128; a++) begin
            @(negedge clk); byte_addr = 7'(127 - a);
        end

        ph = "R3 bank";
        @(negedge clk); bank_we = 1'b1; bank_wdata = 2'd2;
        @(negedge clk); bank_we = 1'b0;
        @(negedge clk);

        ph = "R2 registers";
        for (int b = 0; b < 4; b++) begin
            @(negedge clk); bank_we = 1'b1; bank_wdata = 2'(b);
            for (int n = 0; n < 8; n++) begin
                @(negedge clk); bank_we = 1'b0;
                reg_we = 1'b1; reg_idx = 3'(n); reg_wdata = 8'(8'hA0 + b * 8 + n);
                byte_addr = 7'(b * 8 + n);
            end
            @(negedge clk); reg_we = 1'b0;
            for (int n = 0; n < 8; n++) begin
                @(negedge clk); reg_idx = 3'(7 - n); byte_addr = 7'(b * 8 + 7 - n);
            end
        end

        ph = "R4 R5 bits";
        for (int a = 0; a < 128; a++) begin
            @(negedge clk);
            bit_we = 1'b1; bit_addr = 7'(a); bit_wval = a[0] ^ a[3];
            byte_addr = 7'(32 + a / 8);
        end
        @(negedge clk); quiet();
        for (int a = 0; a < 128; a++) begin
            @(negedge clk); bit_addr = 7'(a); byte_addr = 7'(32 + a / 8);
        end

        ph = "R6 byte vs bit";
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            byte_we = 1'b1; byte_addr = 7'(32 + k); byte_wdata = 8'($urandom);
            bit_we = 1'b1; bit_addr = 7'(k * 8 + k % 8);
            bit_wval = ~byte_wdata[k % 8];
            @(negedge clk); quiet();
            @(negedge clk);
        end
        ph = "R6 byte vs reg";
        for (int k = 0; k < 32; k++) begin
            @(negedge clk); bank_we = 1'b1; bank_wdata = 2'(k / 8);
            @(negedge clk); bank_we = 1'b0;
            byte_we = 1'b1; byte_addr = 7'(k); byte_wdata = 8'(k + 8'h40);
            reg_we = 1'b1; reg_idx = 3'(k % 8); reg_wdata = 8'(8'hC0 - k);
            @(negedge clk); quiet();
            @(negedge clk);
        end

        ph = "R9 scratch";
        for (int a = 48; a < 128; a++) begin
            @(negedge clk); byte_we = 1'b1; byte_addr = 7'(a); byte_wdata = 8'(a ^ 8'h5A);
        end
        @(negedge clk); byte_we = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            bank_we = ($urandom % 4) == 0; bank_wdata = 2'($urandom);
            reg_we = 1'b1; reg_idx = 3'($urandom); reg_wdata = 8'($urandom);
            bit_we = 1'b1; bit_addr = 7'($urandom); bit_wval = 1'($urandom);
            byte_addr = 7'(48 + i % 80);
        end
        @(negedge clk); quiet();
        for (int a = 48; a < 128; a++) begin
            @(negedge clk); byte_addr = 7'(a);
        end

        ph = "R8 contents kept";
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 128; a++) begin
            @(negedge clk); byte_addr = 7'(a); reg_idx = 3'(a); bit_addr = 7'(a);
        end

        ph = "R6 R7 random";
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            bank_we = ($urandom % 8) == 0; bank_wdata = 2'($urandom);
            byte_we = 1'($urandom); byte_addr = 7'($urandom); byte_wdata = 8'($urandom);
            reg_we = 1'($urandom); reg_idx = 3'($urandom); reg_wdata = 8'($urandom);
            bit_we = 1'($urandom); bit_addr = 7'($urandom); bit_wval = 1'($urandom);
            if (($urandom % 4) == 0) byte_addr = 7'(32 + bit_addr / 8);
        end
        @(negedge clk); quiet();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule